// File: doc/BRIEF.md
# Real-Mode Physical Address Generator with Line-20 Gate

This block builds a physical address the way a legacy real-mode machine does. A 16-bit segment is shifted left by four bit positions and added to a 16-bit offset. The 21-bit result is then placed on a 24-bit physical address bus.

Address line 20 passes through an AND with a gate bit that software writes through a one-bit register port. When the gate is clear, any carry into bit 20 is dropped. The address then wraps to low memory, which reproduces the behaviour of the old 20-bit machine. When the gate is set, the carry reaches bit 20 and selects memory just above 1 MB.

A caller presents a segment and an offset with a request strobe. One cycle later the registered address appears with a single-cycle valid flag. The gate register is written with its own strobe and data bit, independently of requests.

Top module: `ra_addr_gen`

## Requirements
- R1: For every request, the linear address is the segment multiplied by 16 plus the offset. Segment 0x1234 with offset 0x5678 gives 0x0179B8, and segment 0xFF00 with offset 0x0FFF gives 0x0FFFFF.
- R2: While the gate bit is 0, output bit 20 is always 0, so the sum wraps modulo 2^20. Segment 0xFF00 with offset 0x1000 gives 0x000000, and segment 0xFFFF with offset 0xFFFF gives 0x00FFEF.
- R3: While the gate bit is 1, the carry reaches output bit 20. Segment 0xFF00 with offset 0x1000 gives 0x100000, and segment 0xFFFF with offset 0xFFFF gives 0x10FFEF.
- R4: Output bits 23 down to 21 are always 0.
- R5: After reset, the valid flag is 0, the address output is 0, and the gate bit is 0 (wrap behaviour).
- R6: The valid flag is 1 in exactly the cycle after a request is sampled, and 0 otherwise. The address for that request is visible in that same cycle.
- R7: A gate write sampled at a clock edge affects only requests sampled at later edges. A request sampled at the same edge as the write uses the previous gate value. The gate keeps its value when no write occurs.
- R8: When no request is sampled, the address output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Request strobe; samples seg and off |
| seg | input | 16 | Segment value |
| off | input | 16 | Offset value |
| gate_we | input | 1 | Gate register write strobe |
| gate_wd | input | 1 | Gate value to write (1 lets the carry reach bit 20) |
| addr | output | 24 | Registered physical address |
| addr_vld | output | 1 | One-cycle flag marking a new address |

## Verification
The assertions check several properties on every cycle:
- bit 20 stays low after any request taken with the gate clear;
- bit 20 follows the carry of the sum when the gate is set;
- the valid flag tracks the request strobe with one cycle of delay;
- the address holds when no request is taken;
- the gate register changes only on a write.

Only the bench scenarios can show the exact arithmetic values. This includes the offsets on either side of the 1 MB crossing with the gate both clear and set. The scenarios also cover three cases that no single-cycle property captures: the ordering of a gate write against a request at the same edge, the effect of an asynchronous reset applied mid-run, and the high bits staying at zero.

// File: rtl/ra_pkg.sv
package ra_pkg;
  localparam int SEG_W_DEF  = 16;
  localparam int OFF_W_DEF  = 16;
  localparam int SHIFT_DEF  = 4;
  localparam int PHYS_W_DEF = 24;
  localparam int GATE_B_DEF = 20;

  // width of the raw sum including its carry bit
  function automatic int lin_width(input int seg_w, input int off_w, input int shift);
    int a;
    a = seg_w + shift;
    return ((a > off_w) ? a : off_w) + 1;
  endfunction
endpackage

// File: rtl/ra_sum.sv
module ra_sum #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int LIN_W = 21
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [LIN_W-1:0] lin
);
  always_comb begin
    lin = (LIN_W'(seg) << SHIFT) + LIN_W'(off);
  end
endmodule

// File: rtl/ra_gate_reg.sv
module ra_gate_reg (
  input  logic clk,
  input  logic rst_s_n,
  input  logic we,
  input  logic wd,
  output logic gate_q
);
  logic gate_d;

  always_comb begin
    gate_d = gate_q;
    if (we) gate_d = wd;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) gate_q <= 1'b0;
    else          gate_q <= gate_d;
  end

  AST_GATE_LOADS: assert property (@(posedge clk) disable iff (!rst_s_n)
    we |=> (gate_q == $past(wd)));                                   // R7
  AST_GATE_KEEPS: assert property (@(posedge clk) disable iff (!rst_s_n)
    !we |=> $stable(gate_q));                                        // R7
endmodule

// File: rtl/ra_mask.sv
module ra_mask #(
  parameter int LIN_W  = 21,
  parameter int PHYS_W = 24,
  parameter int GATE_B = 20
) (
  input  logic [LIN_W-1:0]  lin,
  input  logic              gate,
  output logic [PHYS_W-1:0] phys
);
  for (genvar i = 0; i < PHYS_W; i++) begin : g_bit
    if (i == GATE_B) begin : g_gated
      assign phys[i] = lin[i] & gate;
    end else if (i < LIN_W) begin : g_pass
      assign phys[i] = lin[i];
    end else begin : g_zero
      assign phys[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ra_addr_gen.sv
module ra_addr_gen
  import ra_pkg::*;
#(
  parameter int SEG_W  = SEG_W_DEF,
  parameter int OFF_W  = OFF_W_DEF,
  parameter int SHIFT  = SHIFT_DEF,
  parameter int PHYS_W = PHYS_W_DEF,
  parameter int GATE_B = GATE_B_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic              gate_we,
  input  logic              gate_wd,
  output logic [PHYS_W-1:0] addr,
  output logic              addr_vld
);
  localparam int LIN_W = lin_width(SEG_W, OFF_W, SHIFT);

  // reset: asserts asynchronously, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic [LIN_W-1:0]  lin;
  logic              gate_q;
  logic [PHYS_W-1:0] phys;

  ra_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .LIN_W(LIN_W)) u_sum (
    .seg(seg), .off(off), .lin(lin)
  );

  ra_gate_reg u_gate (
    .clk(clk), .rst_s_n(rst_s_n), .we(gate_we), .wd(gate_wd), .gate_q(gate_q)
  );

  ra_mask #(.LIN_W(LIN_W), .PHYS_W(PHYS_W), .GATE_B(GATE_B)) u_mask (
    .lin(lin), .gate(gate_q), .phys(phys)
  );

  logic [PHYS_W-1:0] addr_q, addr_d;
  logic              vld_q, vld_d;

  always_comb begin
    addr_d = addr_q;
    if (req) addr_d = phys;
    vld_d = req;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end

  assign addr     = addr_q;
  assign addr_vld = vld_q;

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    req |=> addr_vld);                                               // R6
  AST_VLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req |=> !addr_vld);                                             // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req |=> $stable(addr));                                         // R8
  AST_WRAP_B20: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req && !gate_q) |=> !addr[GATE_B]);                             // R2
  AST_CARRY_B20: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req && gate_q) |=> (addr[GATE_B] == $past(lin[GATE_B])));       // R3
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    addr_vld |-> (addr[PHYS_W-1:LIN_W] == '0));                      // R4
endmodule

// File: tb/tb_ra_addr_gen.sv
module tb_ra_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [15:0] seg, off;
  logic        gate_we, gate_wd;
  logic [23:0] addr;
  logic        addr_vld;

  int n_chk = 0;
  int n_bad = 0;
  logic cur_gate;

  always #2.5 clk = ~clk;

  ra_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .req(req), .seg(seg), .off(off),
    .gate_we(gate_we), .gate_wd(gate_wd), .addr(addr), .addr_vld(addr_vld)
  );

  // {gate, seg, off, expected address}
  localparam logic [56:0] VEC [13] = '{
    {1'b0, 16'h0000, 16'h0000, 24'h000000},
    {1'b0, 16'h1234, 16'h5678, 24'h0179B8},
    {1'b0, 16'hFF00, 16'h0FFF, 24'h0FFFFF},
    {1'b0, 16'hFF00, 16'h1000, 24'h000000},
    {1'b0, 16'hFFFF, 16'hFFFF, 24'h00FFEF},
    {1'b0, 16'hF000, 16'hFFFF, 24'h0FFFFF},
    {1'b0, 16'hFFFF, 16'h0010, 24'h000000},
    {1'b1, 16'hFF00, 16'h0FFF, 24'h0FFFFF},
    {1'b1, 16'hFF00, 16'h1000, 24'h100000},
    {1'b1, 16'hFFFF, 16'hFFFF, 24'h10FFEF},
    {1'b1, 16'hFFFF, 16'h0010, 24'h100000},
    {1'b1, 16'h1234, 16'h5678, 24'h0179B8},
    {1'b1, 16'hFFFF, 16'h000F, 24'h0FFFFF}
  };

  task automatic check(input string tag, input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic write_gate(input logic v);
    @(negedge clk);
    gate_we = 1'b1; gate_wd = v;
    @(negedge clk);
    gate_we = 1'b0;
    cur_gate = v;
  endtask

  // one request; result checked in the cycle after it is sampled
  task automatic do_req(input string tag, input logic [15:0] s, input logic [15:0] o,
                        input logic [23:0] exp);
    @(negedge clk);
    req = 1'b1; seg = s; off = o;
    @(negedge clk);
    req = 1'b0;
    check({tag, " addr/vld"}, {addr_vld, addr}, {1'b1, exp});
    check("R4 high bits", {22'd0, addr[23:21]}, 25'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; seg = '0; off = '0; gate_we = 1'b0; gate_wd = 1'b0;
    cur_gate = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 reset addr/vld", {addr_vld, addr}, 25'd0);
    do_req("R5 default gate wraps", 16'hFF00, 16'h1000, 24'h000000);

    // vector table: R1 R2 R3 boundaries around 1 MB
    foreach (VEC[i]) begin
      if (VEC[i][56] !== cur_gate) write_gate(VEC[i][56]);
      do_req(VEC[i][56] ? "R3/R1 vector" : "R2/R1 vector",
             VEC[i][55:40], VEC[i][39:24], VEC[i][23:0]);
    end

    // R6 / R8: valid drops and address holds with no request
    @(negedge clk);
    check("R6 vld low idle", {24'd0, addr_vld}, 25'd0);
    check("R8 addr held", {1'b0, addr}, {1'b0, 24'h0FFFFF});
    seg = 16'hFF00; off = 16'h1000;
    @(negedge clk);
    check("R8 addr held, inputs moved", {addr_vld, addr}, {1'b0, 24'h0FFFFF});

    // R7: write to 0 with request at the same edge uses old gate (1)
    @(negedge clk);
    gate_we = 1'b1; gate_wd = 1'b0; req = 1'b1; seg = 16'hFF00; off = 16'h1000;
    @(negedge clk);
    gate_we = 1'b0; req = 1'b0; cur_gate = 1'b0;
    check("R7 same-edge old gate", {addr_vld, addr}, {1'b1, 24'h100000});
    do_req("R7 new gate applies", 16'hFF00, 16'h1000, 24'h000000);
    // R7: repeated requests without write keep gate
    do_req("R7 gate kept", 16'hFFFF, 16'hFFFF, 24'h00FFEF);

    // R5: mid-run reset clears gate
    write_gate(1'b1);
    do_req("R3 before reset", 16'hFFFF, 16'h0010, 24'h100000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R5 async reset clears", {addr_vld, addr}, 25'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_req("R5 gate cleared by reset", 16'hFFFF, 16'h0010, 24'h000000);

    finish_run();
  end
endmodule